// File: doc/BRIEF.md
# Readout protection level controller

This block keeps the flash readout protection level of a device and turns that level into the access enables for flash, the debug port, debug access to RAM and CPU, and debug access to the secure domain. After reset it reads the level held in non-volatile storage. It then accepts requests to move to another level. A request to raise the level is taken straight away. A request to lower it is taken only when its condition is met: an erase of flash, or a passed key check.

There are four levels, ranked from open to closed: open, secure-only, protected and sealed. The secure-only level closes debug access to the secure domain and keeps the rest open, and it exists only while TrustZone is enabled. Moving down from secure-only or protected to open starts a mass-erase request. The level drops only when the erase reports completion. The sealed level can step down to protected only when an external key comparison reports a pass. Every request that is refused raises an error flag for one cycle.

Top module: `rdp_level_ctrl`

## Requirements
- R1: From reset until the stored level is loaded (the third rising clock edge after `rst_n` rises), `level_o` reads sealed (3) and all four access enables are 0.
- R2: The stored code 8'hA5 loads open (0), 8'h5A loads secure-only (1) and 8'hC3 loads protected (2). Any other code loads sealed (3). `level_o` and `req_level_i` use the rank encoding 0=open, 1=secure-only, 2=protected, 3=sealed.
- R3: At open, the enables {flash_ext, dbg_port, dbg_mem, dbg_sec} are 4'b1111.
- R4: At protected, the enables are 4'b0110. At sealed, they are 4'b0000.
- R5: At secure-only with `tz_en_i`=1, the enables are 4'b1110. With `tz_en_i`=0, secure-only gates like protected (4'b0110).
- R6: A request to a higher rank is applied one cycle later. A request to secure-only while `tz_en_i`=0 is refused.
- R7: A request for open from secure-only or protected raises `erase_req_o` one cycle later and leaves the level unchanged. `erase_done_i` sampled while `erase_req_o`=1 sets the level to open and clears `erase_req_o` one cycle later. `erase_done_i` has no effect while `erase_req_o`=0.
- R8: At sealed, a request for protected with `key_ok_i`=1 sets protected one cycle later, without an erase.
- R9: At sealed, a request for a lower rank with `key_ok_i`=0 leaves the level at sealed and keeps `erase_req_o` at 0.
- R10: A refused request pulses `req_err_o` for exactly one cycle, one cycle after the request. Requests are refused for lowering that matches no rule in R7 or R8, for R6's case, for R9's case, and for any request while an erase is pending.
- R11: A request for the current rank changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_code_i | input | 8 | Level code from non-volatile storage |
| tz_en_i | input | 1 | TrustZone enabled |
| req_valid_i | input | 1 | Level-change request strobe |
| req_level_i | input | 2 | Requested level rank |
| key_ok_i | input | 1 | Key comparison passed |
| erase_done_i | input | 1 | Mass erase finished |
| level_o | output | 2 | Current level rank |
| flash_ext_en_o | output | 1 | External flash access allowed |
| dbg_port_en_o | output | 1 | Debug port enabled |
| dbg_mem_en_o | output | 1 | Debug RAM/CPU access allowed |
| dbg_sec_en_o | output | 1 | Debug secure-domain access allowed |
| erase_req_o | output | 1 | Mass-erase request |
| req_err_o | output | 1 | Request refused (one-cycle pulse) |

## Verification
The stored level is loaded at the third rising edge after reset release, because two edges go to the reset synchronizer and one to the load. After a request or an erase-completion pulse, every result comes one edge later. This covers the level, the enables, the erase request and the error pulse. The enables follow the level with no further register, so they change in the same cycle as the level. The bench drives every input on a falling edge and holds it for one full cycle. It checks the results on the next falling edge, which is half a cycle after the edge that takes the results in, so each check lands in the cycle where its result is due.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int CODE_W = 8;
  localparam int RANK_W = 2;

  localparam logic [CODE_W-1:0] CODE_OPEN   = 8'hA5;
  localparam logic [CODE_W-1:0] CODE_SECO   = 8'h5A;
  localparam logic [CODE_W-1:0] CODE_PROT   = 8'hC3;

  typedef enum logic [RANK_W-1:0] {
    RK_OPEN = 2'd0,
    RK_SECO = 2'd1,
    RK_PROT = 2'd2,
    RK_SEAL = 2'd3
  } rank_e;

  typedef struct packed {
    logic flash_ext;
    logic dbg_port;
    logic dbg_mem;
    logic dbg_sec;
  } gates_t;
endpackage

// File: rtl/rdp_code_decode.sv
module rdp_code_decode
  import rdp_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output rank_e             rank_o
);
  // Unknown codes fail closed to the sealed level.
  always_comb begin
    unique case (code_i)
      CODE_OPEN: rank_o = RK_OPEN;
      CODE_SECO: rank_o = RK_SECO;
      CODE_PROT: rank_o = RK_PROT;
      default:   rank_o = RK_SEAL;
    endcase
  end
endmodule

// File: rtl/rdp_transition.sv
module rdp_transition
  import rdp_pkg::*;
(
  input  rank_e             cur_i,
  input  logic              busy_i,
  input  logic              tz_en_i,
  input  logic              req_valid_i,
  input  logic [RANK_W-1:0] req_level_i,
  input  logic              key_ok_i,
  input  logic              erase_done_i,
  output rank_e             nxt_o,
  output logic              nxt_busy_o,
  output logic              nxt_err_o
);
  rank_e req_rank;
  assign req_rank = rank_e'(req_level_i);

  always_comb begin
    nxt_o      = cur_i;
    nxt_busy_o = busy_i;
    nxt_err_o  = 1'b0;
    if (busy_i) begin
      if (erase_done_i) begin
        nxt_o      = RK_OPEN;
        nxt_busy_o = 1'b0;
      end
      if (req_valid_i) nxt_err_o = 1'b1;
    end else if (req_valid_i) begin
      if (req_rank == cur_i) begin
        nxt_err_o = 1'b0;
      end else if (req_rank > cur_i) begin
        if (req_rank == RK_SECO && !tz_en_i) nxt_err_o = 1'b1;
        else                                 nxt_o     = req_rank;
      end else begin
        unique case (cur_i)
          RK_SECO, RK_PROT: begin
            if (req_rank == RK_OPEN) nxt_busy_o = 1'b1;
            else                     nxt_err_o  = 1'b1;
          end
          RK_SEAL: begin
            if (req_rank == RK_PROT && key_ok_i) nxt_o     = RK_PROT;
            else                                 nxt_err_o = 1'b1;
          end
          default: nxt_err_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
  import rdp_pkg::*;
(
  input  rank_e  rank_i,
  input  logic   tz_en_i,
  output gates_t gates_o
);
  always_comb begin
    unique case (rank_i)
      RK_OPEN: gates_o = '{flash_ext: 1'b1, dbg_port: 1'b1, dbg_mem: 1'b1, dbg_sec: 1'b1};
      RK_SECO: gates_o = tz_en_i
                 ? '{flash_ext: 1'b1, dbg_port: 1'b1, dbg_mem: 1'b1, dbg_sec: 1'b0}
                 : '{flash_ext: 1'b0, dbg_port: 1'b1, dbg_mem: 1'b1, dbg_sec: 1'b0};
      RK_PROT: gates_o = '{flash_ext: 1'b0, dbg_port: 1'b1, dbg_mem: 1'b1, dbg_sec: 1'b0};
      default: gates_o = '{flash_ext: 1'b0, dbg_port: 1'b0, dbg_mem: 1'b0, dbg_sec: 1'b0};
    endcase
  end
endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
  import rdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] nv_code_i,
  input  logic              tz_en_i,
  input  logic              req_valid_i,
  input  logic [RANK_W-1:0] req_level_i,
  input  logic              key_ok_i,
  input  logic              erase_done_i,
  output logic [RANK_W-1:0] level_o,
  output logic              flash_ext_en_o,
  output logic              dbg_port_en_o,
  output logic              dbg_mem_en_o,
  output logic              dbg_sec_en_o,
  output logic              erase_req_o,
  output logic              req_err_o
);
  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  rank_e  rank_q, rank_d, load_rank, step_rank;
  logic   busy_q, busy_d, step_busy;
  logic   err_q, err_d, step_err;
  logic   boot_q;
  logic   upd_en;
  gates_t gates;

  rdp_code_decode u_dec (
    .code_i (nv_code_i),
    .rank_o (load_rank)
  );

  rdp_transition u_trn (
    .cur_i        (rank_q),
    .busy_i       (busy_q),
    .tz_en_i      (tz_en_i),
    .req_valid_i  (req_valid_i),
    .req_level_i  (req_level_i),
    .key_ok_i     (key_ok_i),
    .erase_done_i (erase_done_i),
    .nxt_o        (step_rank),
    .nxt_busy_o   (step_busy),
    .nxt_err_o    (step_err)
  );

  // Next-state selection.
  always_comb begin
    if (boot_q) begin
      rank_d = load_rank;
      busy_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      rank_d = step_rank;
      busy_d = step_busy;
      err_d  = step_err;
    end
  end

  assign upd_en = boot_q | req_valid_i | busy_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rank_q <= RK_SEAL;
      busy_q <= 1'b0;
      boot_q <= 1'b1;
    end else if (upd_en) begin
      rank_q <= rank_d;
      busy_q <= busy_d;
      boot_q <= 1'b0;
    end
  end

  // Error pulse register runs every cycle so it clears after one cycle.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= upd_en & err_d;
  end

  rdp_access_gate u_gate (
    .rank_i  (rank_q),
    .tz_en_i (tz_en_i),
    .gates_o (gates)
  );

  assign level_o        = rank_q;
  assign flash_ext_en_o = gates.flash_ext;
  assign dbg_port_en_o  = gates.dbg_port;
  assign dbg_mem_en_o   = gates.dbg_mem;
  assign dbg_sec_en_o   = gates.dbg_sec;
  assign erase_req_o    = busy_q;
  assign req_err_o      = err_q;
endmodule

// File: rtl/rdp_level_ctrl_chk.sv
module rdp_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boot_q,
  input logic [1:0] level_o,
  input logic       flash_ext_en_o,
  input logic       dbg_port_en_o,
  input logic       dbg_mem_en_o,
  input logic       dbg_sec_en_o,
  input logic       erase_req_o,
  input logic       req_err_o,
  input logic       req_valid_i,
  input logic [1:0] req_level_i,
  input logic       key_ok_i,
  input logic       erase_done_i
);
  // R4: sealed level closes every access path
  assert_sealed_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'd3) |-> !(flash_ext_en_o || dbg_port_en_o || dbg_mem_en_o || dbg_sec_en_o));

  // R3: open level opens every access path
  assert_open_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'd0) |-> (flash_ext_en_o && dbg_port_en_o && dbg_mem_en_o && dbg_sec_en_o));

  // R7: erase request only pending from secure-only or protected
  assert_erase_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> (level_o == 2'd1 || level_o == 2'd2));

  // R7: completion of erase lands on open
  assert_erase_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req_o && erase_done_i) |=> (level_o == 2'd0 && !erase_req_o));

  // R9: failed key check at sealed keeps the level and starts no erase
  assert_key_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && level_o == 2'd3 && req_valid_i && req_level_i != 2'd3 && !key_ok_i)
      |=> (level_o == 2'd3 && !erase_req_o && req_err_o));

  // R10: error only follows a request
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err_o |-> $past(req_valid_i));

  // R8: any downward move needs an erase completion or a key pass
  assert_down_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && !$past(boot_q) && level_o < $past(level_o))
      |-> ($past(erase_req_o && erase_done_i) || $past(key_ok_i && level_o == 2'd3)));
endmodule

bind rdp_level_ctrl rdp_level_ctrl_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .boot_q         (boot_q),
  .level_o        (level_o),
  .flash_ext_en_o (flash_ext_en_o),
  .dbg_port_en_o  (dbg_port_en_o),
  .dbg_mem_en_o   (dbg_mem_en_o),
  .dbg_sec_en_o   (dbg_sec_en_o),
  .erase_req_o    (erase_req_o),
  .req_err_o      (req_err_o),
  .req_valid_i    (req_valid_i),
  .req_level_i    (req_level_i),
  .key_ok_i       (key_ok_i),
  .erase_done_i   (erase_done_i)
);

// File: tb/rdp_level_ctrl_tb.sv
module rdp_level_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] nv_code = 8'h00;
  logic       tz_en = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_level = 2'd0;
  logic       key_ok = 1'b0;
  logic       erase_done = 1'b0;
  logic [1:0] level;
  logic       flash_en, port_en, mem_en, sec_en, erase_req, req_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rdp_level_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .nv_code_i      (nv_code),
    .tz_en_i        (tz_en),
    .req_valid_i    (req_valid),
    .req_level_i    (req_level),
    .key_ok_i       (key_ok),
    .erase_done_i   (erase_done),
    .level_o        (level),
    .flash_ext_en_o (flash_en),
    .dbg_port_en_o  (port_en),
    .dbg_mem_en_o   (mem_en),
    .dbg_sec_en_o   (sec_en),
    .erase_req_o    (erase_req),
    .req_err_o      (req_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gates();
    return {28'd0, flash_en, port_en, mem_en, sec_en};
  endfunction

  task automatic boot(input logic [7:0] code, input logic tz);
    @(negedge clk);
    rst_n = 1'b0; nv_code = code; tz_en = tz;
    req_valid = 1'b0; key_ok = 1'b0; erase_done = 1'b0;
    @(negedge clk);
    check("R1 level in reset", level, 3);
    check("R1 gates in reset", gates(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 gates before load", gates(), 0);
    @(negedge clk);
  endtask

  task automatic request(input logic [1:0] lvl, input logic key);
    req_valid = 1'b1; req_level = lvl; key_ok = key;
    @(negedge clk);
    req_valid = 1'b0; key_ok = 1'b0;
  endtask

  task automatic t_codes();
    boot(8'hA5, 1'b1);
    check("R2 open code", level, 0);
    check("R3 open gates", gates(), 4'b1111);
    boot(8'hC3, 1'b1);
    check("R2 prot code", level, 2);
    check("R4 prot gates", gates(), 4'b0110);
    boot(8'h00, 1'b1);
    check("R2 unknown code", level, 3);
    check("R4 sealed gates", gates(), 4'b0000);
    boot(8'h5A, 1'b0);
    check("R2 seco code", level, 1);
    check("R5 seco no tz gates", gates(), 4'b0110);
    tz_en = 1'b1;
    #1;
    check("R5 seco tz gates", gates(), 4'b1110);
  endtask

  task automatic t_raise();
    boot(8'hA5, 1'b0);
    request(2'd1, 1'b0);
    check("R6 seco without tz level", level, 0);
    check("R10 seco without tz err", req_err, 1);
    @(negedge clk);
    check("R10 err one cycle", req_err, 0);
    request(2'd0, 1'b0);
    check("R11 same level", level, 0);
    check("R11 no err", req_err, 0);
    request(2'd2, 1'b0);
    check("R6 raise to prot", level, 2);
    check("R6 no err on raise", req_err, 0);
    check("R4 prot gates", gates(), 4'b0110);
    request(2'd1, 1'b0);
    check("R10 prot to seco refused", level, 2);
    check("R10 prot to seco err", req_err, 1);
  endtask

  task automatic t_erase_regress();
    boot(8'hC3, 1'b1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check("R7 stray erase_done ignored", level, 2);
    request(2'd0, 1'b0);
    check("R7 erase requested", erase_req, 1);
    check("R7 level held during erase", level, 2);
    request(2'd3, 1'b0);
    check("R10 request while busy err", req_err, 1);
    check("R10 busy level held", level, 2);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check("R7 level open after erase", level, 0);
    check("R7 erase req cleared", erase_req, 0);
    request(2'd1, 1'b0);
    check("R6 raise to seco with tz", level, 1);
    check("R5 seco gates", gates(), 4'b1110);
    request(2'd0, 1'b0);
    check("R7 seco erase requested", erase_req, 1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check("R7 seco to open", level, 0);
  endtask

  task automatic t_sealed();
    boot(8'hA5, 1'b1);
    request(2'd3, 1'b0);
    check("R6 raise to sealed", level, 3);
    check("R4 sealed gates", gates(), 0);
    request(2'd2, 1'b0);
    check("R9 key fail level", level, 3);
    check("R9 key fail no erase", erase_req, 0);
    check("R10 key fail err", req_err, 1);
    request(2'd0, 1'b1);
    check("R10 sealed to open refused", level, 3);
    check("R10 sealed to open err", req_err, 1);
    request(2'd2, 1'b1);
    check("R8 keyed regression", level, 2);
    check("R8 no erase", erase_req, 0);
    check("R8 no err", req_err, 0);
  endtask

  initial begin
    t_codes();
    t_raise();
    t_erase_regress();
    t_sealed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule